// File: doc/BRIEF.md
# Integer Execution Unit with Extend Flag

This block executes one already-decoded integer operation per clock on a source and a destination operand. Each operation works at byte, word or long size. The result goes to a registered output. Five condition flags update at the same edge: extend (X), negative (N), zero (Z), overflow (V) and carry (C). Nothing here generates addresses, accesses memory, multiplies, divides or decodes instructions.

The extend flag holds the carry or borrow of the last arithmetic operation. The extended add, subtract and negate fold it into their results. Because these operations only ever clear Z, a chain of them can add or subtract multiword values and still give a correct zero test over the whole value. The flag register can also be loaded directly. Code that starts a chain uses this to preset X and Z.

Top module: `int_exec_unit`

## Requirements
- R1: After reset, result_o and flags_o are zero. A command is accepted when valid_i or flags_wr_i is high, and its effect shows one clock later. With both low, result_o and flags_o hold.
- R2: size_i selects the operand size: 0 is byte, 1 is word, and 2 or 3 is long. Unless an operation states its own size, it uses only the low bits of that size, result_o keeps dst_i above them, and N and Z come from the sized value.
- R3: Move (op 0) returns src_i at the selected size. It sets N and Z from that value, clears V and C, and leaves X unchanged.
- R4: Add (op 1) returns dst+src. Add-quick (op 2) returns dst plus a literal of 1 to 8 taken from src_i[2:0], where 0 stands for 8. Both put the carry out of the sized MSB in C and X, and set V on signed overflow.
- R5: Add-extended (op 3) returns dst+src+X. It sets C, X and V like add. It clears Z on a nonzero result and leaves Z unchanged otherwise.
- R6: Subtract (op 4) returns dst-src, and subtract-extended (op 5) returns dst-src-X. Both put the borrow in C and X. V is set when the operand signs differ and the result sign differs from dst. Op 5 handles Z like op 3.
- R7: Negate (op 6) returns 0-dst, and negate-extended (op 7) returns 0-dst-X. Both use the borrow and overflow rules of subtract. Op 7 handles Z like op 3.
- R8: Clear (op 8) returns zero at the selected size, sets Z, clears N, V and C, and keeps X.
- R9: Sign-extend (op 9) works at word size (size 0 or 1) or long size (size 2 or 3). At word size it copies dst bit 7 into bits 15:8. At long size it copies dst bit 15 into bits 31:16. N and Z come from that width, V and C clear, and X holds.
- R10: Swap (op 10) exchanges the upper and lower 16-bit halves of dst. It sets N and Z from the 32-bit result, clears V and C, and keeps X.
- R11: Move-quick (op 11) returns src_i[7:0] sign-extended to 32 bits, so -3 gives 0xFFFFFFFD. N and Z follow the result, V and C clear, and X holds.
- R12: When flags_wr_i is high, flags_o takes flags_load_i at the next edge. This applies even if valid_i is high in the same cycle. Bit positions are 4=X, 3=N, 2=Z, 1=V, 0=C.
- R13: With valid_i high, op codes 12 to 15 change neither result_o nor flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute op_i this cycle |
| op_i | input | 4 | Decoded operation code |
| size_i | input | 2 | Operand size select |
| src_i | input | 32 | Source operand or literal |
| dst_i | input | 32 | Destination operand |
| flags_wr_i | input | 1 | Load the flag register directly |
| flags_load_i | input | 5 | Flag value to load {X,N,Z,V,C} |
| result_o | output | 32 | Registered result |
| flags_o | output | 5 | Flag register {X,N,Z,V,C} |

## Verification
The bench builds the unit with its default 32-bit data width. At that width the byte, word and long slices each have their own carry and overflow position, so all three sizes can be exercised. Directed vectors cover carry out of each width, signed overflow, the add-quick literal of 8, and a two-word extended add whose zero flag spans both words. Random vectors mix every opcode, including the unused ones, with direct flag loads and idle cycles, so extended operations start from arbitrary X and Z values.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [3:0] {
    OP_MOVE  = 4'd0,
    OP_ADD   = 4'd1,
    OP_ADDQ  = 4'd2,
    OP_ADDX  = 4'd3,
    OP_SUB   = 4'd4,
    OP_SUBX  = 4'd5,
    OP_NEG   = 4'd6,
    OP_NEGX  = 4'd7,
    OP_CLR   = 4'd8,
    OP_EXT   = 4'd9,
    OP_SWAP  = 4'd10,
    OP_MOVEQ = 4'd11
  } exu_op_e;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_W = 2'd1;
  localparam logic [1:0] SZ_L = 2'd2;

  localparam int FL_X = 4;
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_V = 1;
  localparam int FL_C = 0;
endpackage

// File: rtl/exu_adder.sv
module exu_adder import exu_pkg::*; #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  input  logic [1:0]    size_i,
  output logic [DW-1:0] sum_o,
  output logic          carry_o,
  output logic          ovf_o
);
  localparam int HW = DW / 2;
  localparam int BW = DW / 4;

  logic [DW-1:0] b_eff;
  logic          ci;
  logic [BW:0]   s_b;
  logic [HW:0]   s_h;
  logic [DW:0]   s_l;
  logic          c_raw;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign ci    = sub_i ? ~cin_i : cin_i;

  assign s_b = {1'b0, a_i[BW-1:0]} + {1'b0, b_eff[BW-1:0]} + {{BW{1'b0}}, ci};
  assign s_h = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, ci};
  assign s_l = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, ci};

  assign sum_o = s_l[DW-1:0];

  always_comb begin
    unique case (size_i)
      SZ_B: begin
        c_raw = s_b[BW];
        ovf_o = (a_i[BW-1] == b_eff[BW-1]) && (s_b[BW-1] != a_i[BW-1]);
      end
      SZ_W: begin
        c_raw = s_h[HW];
        ovf_o = (a_i[HW-1] == b_eff[HW-1]) && (s_h[HW-1] != a_i[HW-1]);
      end
      default: begin
        c_raw = s_l[DW];
        ovf_o = (a_i[DW-1] == b_eff[DW-1]) && (s_l[DW-1] != a_i[DW-1]);
      end
    endcase
  end

  // subtract reports borrow, not carry
  assign carry_o = sub_i ? ~c_raw : c_raw;
endmodule

// File: rtl/exu_shape.sv
module exu_shape import exu_pkg::*; #(
  parameter int DW = 32
) (
  input  exu_op_e       op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] sum_i,
  output logic [DW-1:0] res_o,
  output logic          neg_o,
  output logic          zero_o
);
  localparam int HW = DW / 2;
  localparam int BW = DW / 4;

  logic [DW-1:0] val;

  always_comb begin
    unique case (op_i)
      OP_MOVE:  val = src_i;
      OP_CLR:   val = '0;
      OP_EXT:   val = (size_i == SZ_W) ? {{HW{1'b0}}, {(HW-BW){dst_i[BW-1]}}, dst_i[BW-1:0]}
                                       : {{HW{dst_i[HW-1]}}, dst_i[HW-1:0]};
      OP_SWAP:  val = {dst_i[HW-1:0], dst_i[DW-1:HW]};
      OP_MOVEQ: val = {{(DW-8){src_i[7]}}, src_i[7:0]};
      default:  val = sum_i;
    endcase
  end

  always_comb begin
    unique case (size_i)
      SZ_B: begin
        res_o  = {dst_i[DW-1:BW], val[BW-1:0]};
        neg_o  = val[BW-1];
        zero_o = (val[BW-1:0] == '0);
      end
      SZ_W: begin
        res_o  = {dst_i[DW-1:HW], val[HW-1:0]};
        neg_o  = val[HW-1];
        zero_o = (val[HW-1:0] == '0);
      end
      default: begin
        res_o  = val;
        neg_o  = val[DW-1];
        zero_o = (val == '0);
      end
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit import exu_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic          flags_wr_i,
  input  logic [4:0]    flags_load_i,
  output logic [DW-1:0] result_o,
  output logic [4:0]    flags_o
);
  exu_op_e       op;
  logic          op_ok, arith, extended;
  logic [1:0]    sz_eff;
  logic [DW-1:0] add_a, add_b, sum, res;
  logic          add_cin, add_sub, carry, ovf, neg, zero;
  logic [4:0]    flags_d;

  assign op       = exu_op_e'(op_i);
  assign op_ok    = (op_i <= 4'(OP_MOVEQ));
  assign arith    = (op inside {OP_ADD, OP_ADDQ, OP_ADDX, OP_SUB, OP_SUBX, OP_NEG, OP_NEGX});
  assign extended = (op inside {OP_ADDX, OP_SUBX, OP_NEGX});

  always_comb begin
    sz_eff = (size_i == 2'd3) ? SZ_L : size_i;
    if (op == OP_SWAP || op == OP_MOVEQ) sz_eff = SZ_L;
    else if (op == OP_EXT && size_i == SZ_B) sz_eff = SZ_W;
  end

  always_comb begin
    add_a   = dst_i;
    add_b   = src_i;
    add_cin = 1'b0;
    add_sub = 1'b0;
    unique case (op)
      OP_ADDQ: add_b = {{(DW-4){1'b0}}, (src_i[2:0] == 3'd0), src_i[2:0]};
      OP_ADDX: add_cin = flags_o[FL_X];
      OP_SUB:  add_sub = 1'b1;
      OP_SUBX: begin add_sub = 1'b1; add_cin = flags_o[FL_X]; end
      OP_NEG:  begin add_sub = 1'b1; add_a = '0; add_b = dst_i; end
      OP_NEGX: begin add_sub = 1'b1; add_a = '0; add_b = dst_i; add_cin = flags_o[FL_X]; end
      default: ;
    endcase
  end

  exu_adder #(.DW(DW)) u_adder (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin), .sub_i(add_sub),
    .size_i(sz_eff), .sum_o(sum), .carry_o(carry), .ovf_o(ovf)
  );

  exu_shape #(.DW(DW)) u_shape (
    .op_i(op), .size_i(sz_eff), .src_i(src_i), .dst_i(dst_i),
    .sum_i(sum), .res_o(res), .neg_o(neg), .zero_o(zero)
  );

  always_comb begin
    flags_d       = flags_o;
    flags_d[FL_N] = neg;
    if (arith) begin
      flags_d[FL_X] = carry;
      flags_d[FL_C] = carry;
      flags_d[FL_V] = ovf;
      flags_d[FL_Z] = extended ? (flags_o[FL_Z] & zero) : zero;
    end else begin
      flags_d[FL_C] = 1'b0;
      flags_d[FL_V] = 1'b0;
      flags_d[FL_Z] = zero;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      if (valid_i && op_ok) result_o <= res;
      if (flags_wr_i)                flags_o <= flags_load_i;
      else if (valid_i && op_ok)     flags_o <= flags_d;
    end
  end

  // R12
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_wr_i |=> flags_o == $past(flags_load_i));

  // R8
  clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'(OP_CLR) && !flags_wr_i) |=> flags_o[3:0] == 4'b0100);

  // R11
  moveq_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'(OP_MOVEQ)) |=>
      result_o == {{(DW-8){$past(src_i[7])}}, $past(src_i[7:0])});

  // R5
  ext_zero_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && extended && op_ok && !flags_o[FL_Z] && !flags_wr_i) |=> !flags_o[FL_Z]);

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !flags_wr_i) |=> ($stable(result_o) && $stable(flags_o)));

  // R3
  move_vc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'(OP_MOVE) && !flags_wr_i) |=>
      (flags_o[1:0] == 2'b00 && flags_o[FL_X] == $past(flags_o[FL_X])));

  // R13
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'(OP_MOVEQ) && !flags_wr_i) |=>
      ($stable(result_o) && $stable(flags_o)));
endmodule

// File: tb/int_exec_unit_tb_top.sv
`timescale 1ns/1ps
module int_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] src = '0, dst = '0;
  logic        fwr = 1'b0;
  logic [4:0]  fld = '0;
  logic [31:0] result;
  logic [4:0]  flags;

  logic [31:0] exp_res = '0;
  logic [4:0]  exp_fl = '0;
  int n_vec = 0, n_bad = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  int_exec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .src_i(src), .dst_i(dst), .flags_wr_i(fwr), .flags_load_i(fld),
    .result_o(result), .flags_o(flags)
  );

  function automatic string tag_of(input int o);
    case (o)
      0: return "R3";  1, 2: return "R4"; 3: return "R5";
      4, 5: return "R6"; 6, 7: return "R7"; 8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R13";
    endcase
  endfunction

  // behavioural reference: flags {X,N,Z,V,C}
  task automatic model(input int o, input int sz, input logic [31:0] s, d,
                       input logic [4:0] fi, output logic [31:0] r_o, output logic [4:0] f_o);
    int w; longint unsigned mask, a, b, r; longint sd; logic x, c, v, z, n;
    x = fi[4]; c = 0; v = 0;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    if (o == 9)  w = (sz >= 2) ? 32 : 16;
    if (o == 10 || o == 11) w = 32;
    mask = (64'd1 << w) - 1;
    a = d & mask; b = s & mask;
    case (o)
      0: r = b;
      1, 2, 3: begin
        if (o == 2) b = (s[2:0] == 0) ? 8 : s[2:0];
        r = a + b + ((o == 3) ? x : 0);
        c = r[w];
        r = r & mask;
        v = (((a ^ r) & (b ^ r)) >> (w - 1)) & 1;
      end
      4, 5, 6, 7: begin
        if (o >= 6) begin b = a; a = 0; end
        sd = longint'(a) - longint'(b) - ((o == 5 || o == 7) ? x : 0);
        c = sd < 0;
        r = longint'(sd) & mask;
        v = (((a ^ b) & (a ^ r)) >> (w - 1)) & 1;
      end
      8: r = 0;
      9: r = (w == 16) ? ((d[7] ? 64'hFF00 : 0) | d[7:0]) : ((d[15] ? 64'hFFFF0000 : 0) | d[15:0]);
      10: r = {d[15:0], d[31:16]};
      11: r = {{24{s[7]}}, s[7:0]};
      default: r = 0;
    endcase
    n = (r >> (w - 1)) & 1;
    z = (r == 0);
    if (o == 3 || o == 5 || o == 7) z = fi[2] & z;
    r_o = (d & ~32'(mask)) | 32'(r);
    f_o = (o >= 1 && o <= 7) ? {c, n, z, v, c} : {x, n, z, 2'b00};
  endtask

  task automatic check(input string tag);
    n_vec++;
    if (result !== exp_res || flags !== exp_fl) begin
      n_bad++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               tag, result, flags, exp_res, exp_fl);
    end
  endtask

  // drive at negedge, compare at following negedge
  task automatic step(input int o, sz, input logic [31:0] s, d,
                      input logic v, w, input logic [4:0] l, input string tag);
    logic [31:0] r; logic [4:0] f;
    op = 4'(o); size = 2'(sz); src = s; dst = d; valid = v; fwr = w; fld = l;
    if (v && o <= 11) begin
      model(o, sz, s, d, exp_fl, r, f);
      exp_res = r; exp_fl = f;
    end
    if (w) exp_fl = l;
    @(negedge clk);
    check(tag);
  endtask

  task automatic run(input int o, sz, input logic [31:0] s, d, input string tag);
    step(o, sz, s, d, 1'b1, 1'b0, 5'd0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");

    run(0, 0, 32'h0000_0080, 32'h1234_5678, "R3 R2 move byte");
    run(0, 1, 32'hFFFF_0000, 32'hAAAA_5555, "R3 R2 move word zero");
    run(1, 2, 32'hFFFF_FFFF, 32'h0000_0001, "R4 add carry");
    run(1, 1, 32'h0000_0001, 32'h1111_7FFF, "R4 R2 add word overflow");
    run(1, 0, 32'h0000_0001, 32'h0000_00FF, "R4 R2 add byte carry");
    run(2, 2, 32'h0000_0000, 32'h0000_0010, "R4 addq literal 8");
    run(2, 2, 32'h0000_0003, 32'h0000_0010, "R4 addq literal 3");
    step(0, 0, 0, 0, 1'b0, 1'b1, 5'b00100, "R12 preset chain");
    run(3, 2, 32'hFFFF_FFFF, 32'h0000_0001, "R5 addx low word");
    run(3, 2, 32'h0000_0000, 32'h0000_0000, "R5 addx high word");
    run(3, 2, 32'h0000_0000, 32'h0000_0000, "R5 addx zero keeps Z");
    run(4, 2, 32'h0000_0001, 32'h0000_0000, "R6 sub borrow");
    run(5, 1, 32'h0000_0000, 32'h0000_8000, "R6 subx overflow");
    run(6, 0, 32'h0000_0000, 32'h0000_0080, "R7 neg byte min");
    run(7, 2, 32'h0000_0000, 32'h0000_0000, "R7 negx");
    run(8, 1, 32'h0, 32'hDEAD_BEEF, "R8 clr word");
    run(9, 1, 32'h0, 32'h1234_56F0, "R9 ext word");
    run(9, 2, 32'h0, 32'h0000_8000, "R9 ext long");
    run(10, 0, 32'h0, 32'h1234_ABCD, "R10 swap");
    run(11, 0, 32'hFFFF_FFFD, 32'h5555_5555, "R11 moveq -3");
    step(1, 2, 32'h1, 32'h2, 1'b0, 1'b0, 5'd0, "R1 idle hold");
    run(13, 2, 32'h1, 32'h2, "R13 unused op");
    step(1, 2, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b1, 5'b01010, "R12 load wins");

    for (int i = 0; i < 3000; i++) begin
      int o, sz, k;
      logic [31:0] s, d;
      o = $urandom_range(0, 15); sz = $urandom_range(0, 3); k = $urandom_range(0, 9);
      s = $urandom; d = $urandom;
      if (k == 0) d = 32'hFFFF_FFFF;
      if (k == 1) s = 32'h0;
      if (k == 2) step(o, sz, s, d, 1'b0, 1'b1, 5'($urandom), "R12 random load");
      else if (k == 3) step(o, sz, s, d, 1'b0, 1'b0, 5'd0, "R1 random idle");
      else run(o, sz, s, d, tag_of(o));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: result=%h flags=%b expected completion", result, flags);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule